// File: doc/BRIEF.md
# Converter Output Test Pattern Generator

This block sits on the data path of a multi-bit analog-to-digital converter, just before the output serializer. When a test mode is selected, it replaces the converted sample with a known digital word. A receiver can then confirm that it captures the data correctly. It produces one word per sample clock, at a configured word width of 8 to 14 bits. The word is right-justified, and the bits above the width read zero. Several patterns alternate between a first and a second word on successive samples. Two pseudo-noise patterns come from linear feedback shift registers.

A 4-bit mode input picks the pattern. Two user words supply custom data. A format select chooses offset binary or two's complement for the patterns where sign coding matters. The format select has no effect on the other patterns. Any change of mode restarts the alternation on the first word and reseeds a pseudo-noise generator that is being entered.

Top module: `adc_testpat_gen`

## Requirements
- R1: `data_out` is a register with one clock of latency from the inputs. While `rst_n` is low it reads zero, and the alternation phase returns to the first word.
- R2: Mode 0 (off) and the unused codes 13, 14 and 15 copy `sample_in` to `data_out` unchanged.
- R3: Mode 1 gives a word with only bit w-1 set. Mode 2 gives w ones. Mode 3 gives all zeros. Here w is the effective width. With `fmt_twos`=1, bit w-1 of these three words is inverted. For every mode except pass-through and the pseudo-noise modes, bits at and above w are zero.
- R4: Mode 4 alternates between a w-bit word with 1 at bit w-1 and at every second bit below it, and that word's w-bit complement. Mode 7 alternates between w ones and all zeros. Both start on the first word.
- R5: Mode 8 alternates between the low w bits of `user_word1` and the low w bits of `user_word2`, starting on `user_word1`.
- R6: Mode 9 repeats the first checkerboard word on every sample. Mode 11 repeats a word with only bit w-1 set.
- R7: Mode 10 sets the low floor(w/2) bits, for example 0x0F at w=8 and 0x7F at w=14.
- R8: Mode 12 gives 0xA3, 0x263, 0xA33 or 0x2867 at widths 8, 10, 12 and 14. An odd width uses the word of the next lower even width.
- R9: A `cfg_width` value below 8 acts as 8, and a value above 14 acts as 14.
- R10: On the first sample after any change of `mode`, an alternating pattern gives its first word, whatever the phase was before.
- R11: Mode 6 uses a 9-bit LFSR with feedback s[8]^s[4] (x^9+x^5+1), seeded to all ones in the first cycle of the mode. Each sample shifts it 10 times. The 10 feedback bits form the word, with the first bit in bit 9. Width is ignored, and bits 10 and above are zero.
- R12: Mode 5 works the same way with a 23-bit LFSR and feedback s[22]^s[17] (x^23+x^18+1).
- R13: With `fmt_twos`=1, bit 9 of a pseudo-noise word is inverted. `fmt_twos` has no effect on modes 4 and 7 to 12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 4 | Pattern select code |
| cfg_width | input | 4 | Output word width, 8 to 14 |
| fmt_twos | input | 1 | 1 selects two's complement, 0 selects offset binary |
| user_word1 | input | MAX_W (14) | First user word |
| user_word2 | input | MAX_W (14) | Second user word |
| sample_in | input | MAX_W (14) | Converted sample for pass-through |
| data_out | output | MAX_W (14) | Registered output word |

## Verification
A mode change and the word-1/word-2 alternation can act in the same cycle. The phase toggles on every sample, and a change of mode must override it. The bench leaves the block on the second word of checkerboard and then changes mode (checkerboard to user, user to word toggle, word toggle to checkerboard). It expects the first word of the new pattern. It also expects a fresh seed when a pseudo-noise mode is left and re-entered. A change of format select in the same cycle as a step of the alternation is judged at the ports. Alternating patterns must keep their sequence, and pseudo-noise words must differ from the offset-binary sequence only in bit 9.

// File: rtl/adc_tp_pkg.sv
package adc_tp_pkg;
   typedef enum logic [3:0] {
      TP_OFF   = 4'd0,
      TP_MID   = 4'd1,
      TP_PFS   = 4'd2,
      TP_NFS   = 4'd3,
      TP_CHK   = 4'd4,
      TP_PNL   = 4'd5,
      TP_PNS   = 4'd6,
      TP_WTOG  = 4'd7,
      TP_USER  = 4'd8,
      TP_BTOG  = 4'd9,
      TP_SYNC  = 4'd10,
      TP_ONEHI = 4'd11,
      TP_MIX   = 4'd12
   } tp_mode_e;

   localparam int unsigned TP_MIN_W = 8;
   localparam int unsigned TP_TOP_W = 14;
endpackage

// File: rtl/adc_tp_width.sv
module adc_tp_width
   import adc_tp_pkg::*;
(
   input  logic [3:0] cfg_width,
   output logic [3:0] w_eff
);
   always_comb begin
      if (int'(cfg_width) < int'(TP_MIN_W))      w_eff = 4'(TP_MIN_W);
      else if (int'(cfg_width) > int'(TP_TOP_W)) w_eff = 4'(TP_TOP_W);
      else                                       w_eff = cfg_width;
   end
endmodule

// File: rtl/adc_tp_words.sv
module adc_tp_words #(
   parameter int MAX_W = 14
) (
   input  logic [3:0]       w_eff,
   output logic [MAX_W-1:0] mask,
   output logic [MAX_W-1:0] msb_word,
   output logic [MAX_W-1:0] chk_a,
   output logic [MAX_W-1:0] chk_b,
   output logic [MAX_W-1:0] sync_word,
   output logic [MAX_W-1:0] mix_word
);
   logic [3:0] w_m1;
   assign w_m1 = w_eff - 4'd1;

   always_comb begin
      for (int i = 0; i < MAX_W; i++) begin
         mask[i]      = (i < int'(w_eff));
         msb_word[i]  = (i == int'(w_m1));
         chk_a[i]     = (i < int'(w_eff)) && (i[0] == w_m1[0]);
         sync_word[i] = (i < int'(w_eff >> 1));
      end
      chk_b = mask & ~chk_a;
   end

   always_comb begin
      case (w_eff & 4'b1110)
         4'd8:    mix_word = MAX_W'(14'h00A3);
         4'd10:   mix_word = MAX_W'(14'h0263);
         4'd12:   mix_word = MAX_W'(14'h0A33);
         default: mix_word = MAX_W'(14'h2867);
      endcase
   end
endmodule

// File: rtl/adc_tp_lfsr.sv
module adc_tp_lfsr #(
   parameter int LEN   = 9,
   parameter int TAP   = 5,
   parameter int OUT_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             load,
   output logic [OUT_W-1:0] word
);
   logic [LEN-1:0] state_q;
   logic [LEN-1:0] stage [0:OUT_W];

   assign stage[0] = load ? {LEN{1'b1}} : state_q;

   for (genvar k = 0; k < OUT_W; k++) begin : g_step
      logic fb;
      assign fb           = stage[k][LEN-1] ^ stage[k][TAP-1];
      assign stage[k+1]   = {stage[k][LEN-2:0], fb};
      assign word[OUT_W-1-k] = fb;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   state_q <= {LEN{1'b1}};
      else if (run) state_q <= stage[OUT_W];
   end
endmodule

// File: rtl/adc_testpat_gen.sv
module adc_testpat_gen
   import adc_tp_pkg::*;
#(
   parameter int MAX_W  = 14,
   parameter int PN_W   = 10,
   parameter int PNS_LEN = 9,
   parameter int PNS_TAP = 5,
   parameter int PNL_LEN = 23,
   parameter int PNL_TAP = 18
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [3:0]       mode,
   input  logic [3:0]       cfg_width,
   input  logic             fmt_twos,
   input  logic [MAX_W-1:0] user_word1,
   input  logic [MAX_W-1:0] user_word2,
   input  logic [MAX_W-1:0] sample_in,
   output logic [MAX_W-1:0] data_out
);
   localparam logic [MAX_W-1:0] PN_MSB = MAX_W'(1) << (PN_W - 1);

   if (MAX_W < int'(TP_TOP_W)) begin : g_bad_width
      $error("MAX_W must cover the widest pattern word");
   end
   if (PN_W > MAX_W || PN_W < 2) begin : g_bad_pn
      $error("PN_W must lie between 2 and MAX_W");
   end
   if (PNS_TAP >= PNS_LEN || PNL_TAP >= PNL_LEN) begin : g_bad_tap
      $error("LFSR tap must lie below the register length");
   end

   tp_mode_e        mode_e;
   logic [3:0]      mode_q;
   logic            phase_q;
   logic            entering;
   logic            ph;
   logic [3:0]      w_eff;
   logic [MAX_W-1:0] mask, msb_word, chk_a, chk_b, sync_word, mix_word;
   logic [PN_W-1:0] pns_word, pnl_word;
   logic [MAX_W-1:0] fmt_flip, pn_flip, pat;

   assign mode_e   = tp_mode_e'(mode);
   assign entering = (mode != mode_q);
   assign ph       = entering ? 1'b0 : phase_q;
   assign fmt_flip = fmt_twos ? msb_word : '0;
   assign pn_flip  = fmt_twos ? PN_MSB : '0;

   adc_tp_width u_width (
      .cfg_width (cfg_width),
      .w_eff     (w_eff)
   );

   adc_tp_words #(.MAX_W(MAX_W)) u_words (
      .w_eff     (w_eff),
      .mask      (mask),
      .msb_word  (msb_word),
      .chk_a     (chk_a),
      .chk_b     (chk_b),
      .sync_word (sync_word),
      .mix_word  (mix_word)
   );

   adc_tp_lfsr #(.LEN(PNS_LEN), .TAP(PNS_TAP), .OUT_W(PN_W)) u_pn_short (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (mode_e == TP_PNS),
      .load  (entering),
      .word  (pns_word)
   );

   adc_tp_lfsr #(.LEN(PNL_LEN), .TAP(PNL_TAP), .OUT_W(PN_W)) u_pn_long (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (mode_e == TP_PNL),
      .load  (entering),
      .word  (pnl_word)
   );

   always_comb begin
      case (mode_e)
         TP_MID:   pat = msb_word ^ fmt_flip;
         TP_PFS:   pat = mask ^ fmt_flip;
         TP_NFS:   pat = fmt_flip;
         TP_CHK:   pat = ph ? chk_b : chk_a;
         TP_PNL:   pat = MAX_W'(pnl_word) ^ pn_flip;
         TP_PNS:   pat = MAX_W'(pns_word) ^ pn_flip;
         TP_WTOG:  pat = ph ? '0 : mask;
         TP_USER:  pat = (ph ? user_word2 : user_word1) & mask;
         TP_BTOG:  pat = chk_a;
         TP_SYNC:  pat = sync_word;
         TP_ONEHI: pat = msb_word;
         TP_MIX:   pat = mix_word;
         default:  pat = sample_in;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_out <= '0;
         mode_q   <= 4'd0;
         phase_q  <= 1'b0;
      end else begin
         data_out <= pat;
         mode_q   <= mode;
         phase_q  <= ~ph;
      end
   end
endmodule

// File: rtl/adc_testpat_gen_chk.sv
module adc_testpat_gen_chk #(
   parameter int MAX_W = 14,
   parameter int PN_W  = 10
) (
   input logic             clk,
   input logic             rst_n,
   input logic [3:0]       mode,
   input logic [3:0]       cfg_width,
   input logic [MAX_W-1:0] sample_in,
   input logic [MAX_W-1:0] data_out
);
   function automatic int wclamp(logic [3:0] c);
      if (c < 4'd8)  return 8;
      if (c > 4'd14) return 14;
      return int'(c);
   endfunction

   function automatic logic [MAX_W-1:0] wmask(int w);
      return (MAX_W'(1) << w) - MAX_W'(1);
   endfunction

   assert_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && ($past(mode) == 4'd0 || $past(mode) > 4'd12))
      |-> data_out == $past(sample_in));

   assert_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && ($past(mode) inside {4'd1, 4'd2, 4'd3, 4'd4, 4'd7, 4'd8,
                                            4'd9, 4'd10, 4'd11, 4'd12}))
      |-> (data_out >> wclamp($past(cfg_width))) == '0);

   assert_chk_alt_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(rst_n, 2) && $past(mode) == 4'd4 &&
       $past(mode, 2) == 4'd4 && $past(cfg_width) == $past(cfg_width, 2))
      |-> (data_out ^ $past(data_out)) == wmask(wclamp($past(cfg_width))));

   assert_onehi_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(mode) == 4'd11) |-> $countones(data_out) == 1);

   assert_entry_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(rst_n, 2) && $past(mode) != $past(mode, 2) &&
       ($past(mode) == 4'd4 || $past(mode) == 4'd7))
      |-> data_out[wclamp($past(cfg_width)) - 1]);

   assert_pn_width_R11: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && ($past(mode) == 4'd5 || $past(mode) == 4'd6))
      |-> (data_out >> PN_W) == '0);
endmodule

bind adc_testpat_gen adc_testpat_gen_chk #(.MAX_W(MAX_W), .PN_W(PN_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .mode      (mode),
   .cfg_width (cfg_width),
   .sample_in (sample_in),
   .data_out  (data_out)
);

// File: tb/adc_testpat_gen_tb.sv
module adc_testpat_gen_tb;
   localparam int W = 14;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [3:0]   mode = 4'd0;
   logic [3:0]   cfg_width = 4'd10;
   logic         fmt_twos = 1'b0;
   logic [W-1:0] user_word1 = '0;
   logic [W-1:0] user_word2 = '0;
   logic [W-1:0] sample_in = '0;
   logic [W-1:0] data_out;

   int errors = 0;
   int checks = 0;
   bit done = 0;

   typedef struct {
      logic [W-1:0] exp;
      string        tag;
   } item_t;
   item_t sb[$];

   logic [3:0]  m_prev = 4'd0;
   bit          m_ph = 0;
   logic [31:0] pns_st = 32'h1FF;
   logic [31:0] pnl_st = 32'h7FFFFF;

   always #4 clk = ~clk;

   adc_testpat_gen u_dut (
      .clk(clk), .rst_n(rst_n), .mode(mode), .cfg_width(cfg_width),
      .fmt_twos(fmt_twos), .user_word1(user_word1), .user_word2(user_word2),
      .sample_in(sample_in), .data_out(data_out)
   );

   function automatic logic [9:0] pn_gen(inout logic [31:0] st, input int len, input int tap);
      logic [9:0] wd = '0;
      for (int k = 0; k < 10; k++) begin
         logic f;
         f  = st[len-1] ^ st[tap-1];
         wd = {wd[8:0], f};
         st = ((st << 1) | 32'(f)) & ((32'd1 << len) - 32'd1);
      end
      return wd;
   endfunction

   task automatic check(input logic [W-1:0] act, input logic [W-1:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // applies one sample's inputs, predicts the word seen after the next edge
   task automatic drive(input logic [3:0] m, input logic [3:0] cw, input bit fm,
                        input logic [W-1:0] smp);
      int w, ent, ph;
      logic [31:0] mask, msb, ca, cb, e;
      string tag;
      mode = m; cfg_width = cw; fmt_twos = fm; sample_in = smp;
      w = (cw < 8) ? 8 : (cw > 14) ? 14 : int'(cw);
      mask = (32'd1 << w) - 1;
      msb  = 32'd1 << (w - 1);
      ca = 0;
      for (int i = 0; i < w; i++) if (((w - 1 - i) % 2) == 0) ca[i] = 1'b1;
      cb = mask & ~ca;
      ent = (m != m_prev);
      ph  = ent ? 0 : int'(m_ph);
      case (m)
         4'd1:  begin e = fm ? 0 : msb;           tag = "R3"; end
         4'd2:  begin e = fm ? mask >> 1 : mask;  tag = "R3"; end
         4'd3:  begin e = fm ? msb : 0;           tag = "R3"; end
         4'd4:  begin e = ph ? cb : ca;           tag = "R4"; end
         4'd5:  begin
                   if (ent) pnl_st = 32'h7FFFFF;
                   e = 32'(pn_gen(pnl_st, 23, 18)) ^ (fm ? 32'h200 : 0); tag = "R12";
                end
         4'd6:  begin
                   if (ent) pns_st = 32'h1FF;
                   e = 32'(pn_gen(pns_st, 9, 5)) ^ (fm ? 32'h200 : 0); tag = "R11";
                end
         4'd7:  begin e = ph ? 0 : mask;          tag = "R4"; end
         4'd8:  begin e = 32'(ph ? user_word2 : user_word1) & mask; tag = "R5"; end
         4'd9:  begin e = ca;                     tag = "R6"; end
         4'd10: begin e = (32'd1 << (w / 2)) - 1; tag = "R7"; end
         4'd11: begin e = msb;                    tag = "R6"; end
         4'd12: begin
                   case (w & ~1)
                      8:  e = 32'h0A3;
                      10: e = 32'h263;
                      12: e = 32'hA33;
                      default: e = 32'h2867;
                   endcase
                   tag = "R8";
                end
         default: begin e = 32'(smp);             tag = "R2"; end
      endcase
      if (fm && (m == 4'd5 || m == 4'd6 || (m >= 4'd7 && m <= 4'd12) || m == 4'd4))
         tag = {tag, "/R13"};
      if (cw < 8 || cw > 14) tag = {tag, "/R9"};
      if (ent && (m == 4'd4 || m == 4'd7 || m == 4'd8)) tag = {tag, "/R10"};
      m_prev = m;
      m_ph   = !ph;
      sb.push_back('{exp: e[W-1:0], tag: tag});
      @(negedge clk);
   endtask

   // monitor: pops one prediction per active edge
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (rst_n && sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            check(data_out, it.exp, it.tag);
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      check(data_out, '0, "R1 reset");
      @(negedge clk);
      rst_n = 1'b1;
      user_word1 = 14'h2A5C;
      user_word2 = 14'h15A3;
      // pass-through, then unused codes
      drive(4'd0, 4'd10, 0, 14'h1234);
      drive(4'd0, 4'd10, 1, 14'h3FFF);
      drive(4'd13, 4'd10, 0, 14'h0ABC);
      drive(4'd15, 4'd8, 1, 14'h2001);
      // every fixed and alternating pattern across widths and formats
      for (int w = 8; w <= 14; w++) begin
         for (int f = 0; f < 2; f++) begin
            drive(4'd1, 4'(w), f[0], '0);
            drive(4'd2, 4'(w), f[0], '0);
            drive(4'd3, 4'(w), f[0], '0);
            drive(4'd4, 4'(w), f[0], '0);
            drive(4'd4, 4'(w), f[0], '0);
            drive(4'd4, 4'(w), f[0], '0);
            drive(4'd7, 4'(w), f[0], '0);
            drive(4'd7, 4'(w), f[0], '0);
            drive(4'd8, 4'(w), f[0], '0);
            drive(4'd8, 4'(w), f[0], '0);
            drive(4'd9, 4'(w), f[0], '0);
            drive(4'd10, 4'(w), f[0], '0);
            drive(4'd11, 4'(w), f[0], '0);
            drive(4'd12, 4'(w), f[0], '0);
         end
      end
      // width clamping
      drive(4'd1, 4'd3, 0, '0);
      drive(4'd10, 4'd0, 0, '0);
      drive(4'd12, 4'd15, 0, '0);
      drive(4'd2, 4'd15, 1, '0);
      // mode change while on the second word
      drive(4'd4, 4'd10, 0, '0);
      drive(4'd4, 4'd10, 0, '0);
      drive(4'd8, 4'd10, 0, '0);
      drive(4'd8, 4'd10, 0, '0);
      drive(4'd7, 4'd12, 0, '0);
      drive(4'd7, 4'd12, 0, '0);
      drive(4'd4, 4'd12, 0, '0);
      // format flip in the middle of an alternation
      drive(4'd4, 4'd12, 1, '0);
      drive(4'd4, 4'd12, 0, '0);
      // pseudo-noise: short, long, format flips, reseed on re-entry
      for (int i = 0; i < 40; i++) drive(4'd6, 4'd8, (i % 7) == 3, '0);
      for (int i = 0; i < 40; i++) drive(4'd5, 4'd14, (i % 5) == 2, '0);
      drive(4'd0, 4'd10, 0, 14'h0001);
      for (int i = 0; i < 5; i++) drive(4'd6, 4'd10, 0, '0);
      for (int i = 0; i < 5; i++) drive(4'd5, 4'd10, 1, '0);
      drive(4'd6, 4'd10, 0, '0);
      repeat (3) @(negedge clk);
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule